// File: doc/BRIEF.md
# Restartable Load/Store Multiple Sequencer

This block runs the execute stage of a multi-register memory instruction: a load-multiple, a store-multiple, and the stack push and pop forms built from them. It is given a bitmask of registers, the number of the register that holds the base address, a direction, a load/store select and a writeback flag. It then moves one 32-bit word per register over a single data memory port. The register with the lowest number goes to the lowest address. An upward transfer starts at the base. A downward (push-style) transfer first steps the base down by four bytes per listed register.

An interrupt-pending input is checked at every beat boundary. If an interrupt is pending and beats remain, the sequencer finishes the beat already on the bus. It then drops the port, so the single memory interface is free for exception stacking, and it gives up the instruction. Loaded words go to a shadow buffer and reach the register file only in a commit cycle after the last beat. Base writeback also waits for that commit cycle. An abandoned instruction therefore leaves every register as it was, and it can be issued again from its first register. A restart repeats memory accesses that were already made, and the surrounding system must tolerate that.

The register file sits inside the block. It has a write port for loading registers and a read port for inspecting them.

Top module: `lsm_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, busy, mem_req, done and aborted are 0, restart_pc is 0 and every register reads 0.
- R2: A started operation with a non-empty list makes exactly one word request per listed register, in ascending register order, at addresses that rise by 4 per beat. The first address is the base value for an upward transfer (desc=0) or the base minus 4 times the register count for a downward one (desc=1). No request is made while busy is low.
- R3: A request stays asserted with the same address, write flag and write data until mem_ack is seen. It is never withdrawn before that, even when an interrupt becomes pending during its wait.
- R4: A store (is_load=0) drives on mem_wdata the register's value from before the instruction. This includes the base register, which is stored with its original value.
- R5: Loaded words are not visible on the register read port before the instruction completes. After an abandoned load every register reads what it held before the start.
- R6: One cycle after the acknowledge of the last beat, the loads and the writeback are applied. In the cycle after that, done is high for exactly one cycle, and the read port already shows the new values. done and aborted are never high together.
- R7: irq_pend is sampled at the start cycle and at each acknowledge. If it is high at the start, or at the acknowledge of a beat that is not the last, aborted pulses for one cycle in the next cycle, busy falls and no further request is made. If it is high only at the acknowledge of the last beat, the instruction completes.
- R8: On an abort, restart_pc takes the instr_pc value given with that instruction's start. It holds that value until the next abort.
- R9: With wback=1 a completed instruction writes the base register with base plus 4 times the count (desc=0) or base minus 4 times the count (desc=1). An abandoned instruction writes nothing. If a load list contains the base register, the loaded word wins over the writeback value.
- R10: Starting with an empty register list makes no request and gives a done pulse two cycles after start. The base register is unchanged.
- R11: start and rf_we are ignored while busy is high. No new request sequence begins and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| reg_list | input | NREG | Register bitmask, bit i selects register i |
| base_idx | input | IW | Number of the base register |
| desc | input | 1 | 1: decrement-before addressing (push form); 0: increment-after |
| is_load | input | 1 | 1: load from memory; 0: store to memory |
| wback | input | 1 | Write the updated base back on completion |
| instr_pc | input | PCW | Address of the instruction being started |
| irq_pend | input | 1 | Interrupt pending |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | One-cycle abandonment pulse |
| restart_pc | output | PCW | Address to resume at after the handler |
| rf_we | input | 1 | Register file write enable (idle only) |
| rf_waddr | input | IW | Register file write index |
| rf_wdata | input | DW | Register file write data |
| rf_raddr | input | IW | Register file read index |
| rf_rdata | output | DW | Register file read data |

## Verification
The bench raises an interrupt in several places: at the start, during the wait state of a beat, at a middle acknowledge and at the final acknowledge. A design that cancels an in-flight request, continues after a middle abort, or abandons a finished last beat would show a different request stream or a missing done. Abandoned loads are compared against a register snapshot, and a load list that contains the base register is run to completion. A design that writes loaded data straight through, writes the base back early, or lets writeback override the loaded word would leave wrong register contents after a replay. Push/pop round trips, an empty list, and start and register writes issued while busy cover the addressing, the store-of-base value and the idle-only acceptance rules.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lsm_regfile.sv
module lsm_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ext_we,
  input  logic [IW-1:0]             ext_idx,
  input  logic [DW-1:0]             ext_data,
  input  logic                      cmt_en,
  input  logic [NREG-1:0]           cmt_mask,
  input  logic [NREG-1:0][DW-1:0]   cmt_data,
  input  logic                      wb_en,
  input  logic [IW-1:0]             wb_idx,
  input  logic [DW-1:0]             wb_data,
  input  logic [IW-1:0]             st_idx,
  output logic [DW-1:0]             st_data,
  input  logic [IW-1:0]             base_idx,
  output logic [DW-1:0]             base_data,
  input  logic [IW-1:0]             dbg_idx,
  output logic [DW-1:0]             dbg_data
);
  logic [DW-1:0] regs_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    // committed load data outranks base writeback, which outranks host writes
    always_ff @(posedge clk) begin
      if (rst)                                   q <= '0;
      else if (cmt_en && cmt_mask[g])            q <= cmt_data[g];
      else if (wb_en && wb_idx == IW'(g))        q <= wb_data;
      else if (ext_we && ext_idx == IW'(g))      q <= ext_data;
    end
    assign regs_w[g] = q;
  end

  assign st_data   = regs_w[st_idx];
  assign base_data = regs_w[base_idx];
  assign dbg_data  = regs_w[dbg_idx];
endmodule

// File: rtl/lsm_shadow.sv
module lsm_shadow #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      cap_en,
  input  logic [IW-1:0]             cap_idx,
  input  logic [DW-1:0]             cap_data,
  output logic [NREG-1:0][DW-1:0]   held
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (cap_en && cap_idx == IW'(g)) q <= cap_data;
    end
    assign held[g] = q;
  end
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int PCW  = 32,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NREG-1:0]   reg_list,
  input  logic [IW-1:0]     base_idx,
  input  logic              desc,
  input  logic              is_load,
  input  logic              wback,
  input  logic [PCW-1:0]    instr_pc,
  input  logic              irq_pend,
  input  logic              mem_ack,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     st_data,
  output logic [IW-1:0]     st_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [PCW-1:0]    restart_pc,
  output logic              cap_en,
  output logic [IW-1:0]     cap_idx,
  output logic              cmt_en,
  output logic [NREG-1:0]   cmt_mask,
  output logic              wb_en,
  output logic [IW-1:0]     wb_idx,
  output logic [DW-1:0]     wb_data
);
  function automatic logic [IW-1:0] lowest(input logic [NREG-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [CW-1:0] popcnt(input logic [NREG-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  seq_state_t         state;
  logic [NREG-1:0]    remain, lst;
  logic               ld, wbf;
  logic [IW-1:0]      bidx, cur;
  logic [PCW-1:0]     pc_q;
  logic [DW-1:0]      fin_q;

  logic [NREG-1:0]    list_src, nxt_rem;
  logic [IW-1:0]      nxt_idx;
  logic [DW-1:0]      span;

  always_comb begin
    list_src = (state == ST_IDLE) ? reg_list : remain;
    nxt_idx  = lowest(list_src);
    nxt_rem  = list_src & ~(NREG'(1) << nxt_idx);
    span     = DW'(popcnt(reg_list)) << 2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  remain <= '0; lst <= '0; ld <= 1'b0; wbf <= 1'b0;
      bidx <= '0; cur <= '0; pc_q <= '0; fin_q <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      done <= 1'b0; aborted <= 1'b0; restart_pc <= '0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          lst   <= reg_list;
          ld    <= is_load;
          wbf   <= wback;
          bidx  <= base_idx;
          pc_q  <= instr_pc;
          fin_q <= desc ? base_val - span : base_val + span;
          if (reg_list == '0) begin
            state <= ST_COMMIT;
          end else if (irq_pend) begin
            aborted    <= 1'b1;
            restart_pc <= instr_pc;
          end else begin
            state     <= ST_XFER;
            mem_req   <= 1'b1;
            mem_we    <= ~is_load;
            mem_addr  <= desc ? base_val - span : base_val;
            mem_wdata <= st_data;
            cur       <= nxt_idx;
            remain    <= nxt_rem;
          end
        end
        ST_XFER: if (mem_ack) begin
          if (remain == '0) begin
            mem_req <= 1'b0;
            state   <= ST_COMMIT;
          end else if (irq_pend) begin
            mem_req    <= 1'b0;
            state      <= ST_IDLE;
            aborted    <= 1'b1;
            restart_pc <= pc_q;
          end else begin
            mem_addr  <= mem_addr + DW'(4);
            mem_wdata <= st_data;
            cur       <= nxt_idx;
            remain    <= nxt_rem;
          end
        end
        ST_COMMIT: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign st_idx   = nxt_idx;
  assign cap_en   = (state == ST_XFER) && mem_ack && ld;
  assign cap_idx  = cur;
  assign cmt_en   = (state == ST_COMMIT) && ld;
  assign cmt_mask = lst;
  assign wb_en    = (state == ST_COMMIT) && wbf;
  assign wb_idx   = bidx;
  assign wb_data  = fin_q;
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int PCW  = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NREG-1:0]   reg_list,
  input  logic [IW-1:0]     base_idx,
  input  logic              desc,
  input  logic              is_load,
  input  logic              wback,
  input  logic [PCW-1:0]    instr_pc,
  input  logic              irq_pend,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [PCW-1:0]    restart_pc,
  input  logic              rf_we,
  input  logic [IW-1:0]     rf_waddr,
  input  logic [DW-1:0]     rf_wdata,
  input  logic [IW-1:0]     rf_raddr,
  output logic [DW-1:0]     rf_rdata
);
  logic [DW-1:0]            base_val, st_data, wb_data;
  logic [IW-1:0]            st_idx, cap_idx, wb_idx;
  logic                     cap_en, cmt_en, wb_en;
  logic [NREG-1:0]          cmt_mask;
  logic [NREG-1:0][DW-1:0]  held;

  lsm_ctrl #(.NREG(NREG), .DW(DW), .PCW(PCW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .reg_list(reg_list), .base_idx(base_idx),
    .desc(desc), .is_load(is_load), .wback(wback), .instr_pc(instr_pc),
    .irq_pend(irq_pend), .mem_ack(mem_ack), .base_val(base_val), .st_data(st_data),
    .st_idx(st_idx), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .aborted(aborted),
    .restart_pc(restart_pc), .cap_en(cap_en), .cap_idx(cap_idx), .cmt_en(cmt_en),
    .cmt_mask(cmt_mask), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  lsm_shadow #(.NREG(NREG), .DW(DW)) u_shadow (
    .clk(clk), .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(mem_rdata), .held(held)
  );

  lsm_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .ext_we(rf_we && !busy), .ext_idx(rf_waddr), .ext_data(rf_wdata),
    .cmt_en(cmt_en), .cmt_mask(cmt_mask), .cmt_data(held),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .st_idx(st_idx), .st_data(st_data),
    .base_idx(base_idx), .base_data(base_val),
    .dbg_idx(rf_raddr), .dbg_data(rf_rdata)
  );
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int DW  = 32,
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_pend,
  input logic           mem_req,
  input logic           mem_we,
  input logic [DW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack,
  input logic           busy,
  input logic           done,
  input logic           aborted,
  input logic [PCW-1:0] restart_pc
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + DW'(4))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(done && aborted)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    aborted |-> !mem_req && !busy); // R7
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    aborted |-> $past(irq_pend)); // R7
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !aborted |-> $stable(restart_pc)); // R8
endmodule

bind lsm_seq lsm_seq_chk #(.DW(DW), .PCW(PCW)) u_chk (.*);

// File: tb/lsm_seq_test.sv
`timescale 1ns/100ps
module lsm_seq_test;
  logic clk = 0, rst = 1;
  logic start = 0, desc = 0, is_load = 0, wback = 0, irq_pend = 0;
  logic [7:0]  reg_list = 0;
  logic [2:0]  base_idx = 0, rf_waddr = 0, rf_raddr = 0;
  logic [31:0] instr_pc = 0, rf_wdata = 0, mem_rdata = 0;
  logic        mem_ack = 0, rf_we = 0;
  logic        mem_req, mem_we, busy, done, aborted;
  logic [31:0] mem_addr, mem_wdata, restart_pc, rf_rdata;

  always #2 clk = ~clk;

  lsm_seq uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0, run_chk = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory and interrupt stimulus
  logic [31:0] mem [logic [31:0]];
  int acks = 0, acks_base = 0, irq_k = -1, wait_cfg = 0, wcnt = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_0F0F);
  endfunction

  always @(negedge clk) begin
    irq_pend = (irq_k >= 0) && ((acks - acks_base) >= irq_k);
    mem_ack = 0;
    if (rst || !mem_req) wcnt = wait_cfg;
    else if (wcnt == 0) begin
      mem_ack = 1;
      acks++;
      mem_rdata = mrd(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
      wcnt = wait_cfg;
    end else wcnt--;
  end

  // behavioural reference model
  logic [31:0] m_rf [8];
  logic [31:0] m_sh [8];
  int          q[$];
  bit          m_busy, m_commit, m_req, m_we, m_done, m_abort;
  logic [31:0] m_addr, m_wdata, m_rpc;
  logic [7:0]  j_list;
  bit          j_ld, j_wb, j_desc;
  int          j_base, j_cnt;
  logic [31:0] j_bval, j_pc;

  always @(posedge clk) begin
    m_done = 0; m_abort = 0;
    if (rst) begin
      m_busy = 0; m_commit = 0; m_req = 0; m_we = 0; m_addr = 0; m_wdata = 0; m_rpc = 0;
      q.delete();
      for (int i = 0; i < 8; i++) m_rf[i] = 0;
    end else if (m_commit) begin
      if (j_ld) for (int i = 0; i < 8; i++) if (j_list[i]) m_rf[i] = m_sh[i];
      if (j_wb && !(j_ld && j_list[j_base]))
        m_rf[j_base] = j_desc ? j_bval - 4 * j_cnt : j_bval + 4 * j_cnt;
      m_commit = 0; m_busy = 0; m_done = 1;
    end else if (!m_busy) begin
      if (rf_we) m_rf[rf_waddr] = rf_wdata;
      if (start) begin
        j_list = reg_list; j_ld = is_load; j_wb = wback; j_desc = desc;
        j_base = base_idx; j_bval = m_rf[base_idx]; j_pc = instr_pc;
        j_cnt = 0;
        q.delete();
        for (int i = 0; i < 8; i++) if (reg_list[i]) begin q.push_back(i); j_cnt++; end
        if (j_cnt == 0) begin m_busy = 1; m_commit = 1; end
        else if (irq_pend) begin m_abort = 1; m_rpc = instr_pc; end
        else begin
          m_busy = 1; m_req = 1; m_we = !is_load;
          m_addr = desc ? j_bval - 4 * j_cnt : j_bval;
          m_wdata = m_rf[q[0]];
        end
      end
    end else if (mem_ack) begin
      if (j_ld) m_sh[q[0]] = mem_rdata;
      void'(q.pop_front());
      if (q.size() == 0) begin m_req = 0; m_commit = 1; end
      else if (irq_pend) begin m_req = 0; m_busy = 0; m_abort = 1; m_rpc = j_pc; end
      else begin m_addr = m_addr + 4; m_wdata = m_rf[q[0]]; end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (run_chk && !rst) begin
    chk(busy, m_busy, "R11 busy");
    chk(mem_req, m_req, "R2 mem_req");
    if (m_req) begin
      chk(mem_addr, m_addr, "R2 mem_addr");
      chk(mem_we, m_we, "R2 mem_we");
      if (m_we) chk(mem_wdata, m_wdata, "R4 mem_wdata");
    end
    chk(done, m_done, "R6 done");
    chk(aborted, m_abort, "R7 aborted");
    chk(restart_pc, m_rpc, "R8 restart_pc");
  end

  task automatic chk_regs(input logic [31:0] e [8], input string tag);
    for (int i = 0; i < 8; i++) begin
      rf_raddr = 3'(i);
      #0.1;
      chk(rf_rdata, e[i], tag);
    end
  endtask

  task automatic rf_write(input int i, input logic [31:0] v);
    @(negedge clk); rf_we = 1; rf_waddr = 3'(i); rf_wdata = v;
    @(negedge clk); rf_we = 0;
  endtask

  task automatic op(input logic [7:0] lst, input int b, input bit dsc, input bit ld,
                    input bit wb, input int k, input int w, input logic [31:0] pc,
                    input bit exp_abort, input bit intrude, input string tag);
    int n;
    @(negedge clk); irq_k = k; acks_base = acks; wait_cfg = w;
    @(negedge clk);
    start = 1; reg_list = lst; base_idx = 3'(b); desc = dsc; is_load = ld;
    wback = wb; instr_pc = pc;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      start = 1; reg_list = 8'hF0; base_idx = 3'd7; is_load = 1;
      rf_we = 1; rf_waddr = 3'd0; rf_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      start = 0; rf_we = 0;
    end
    n = 0;
    while (!done && !aborted && n < 400) begin @(negedge clk); n++; end
    chk({31'd0, aborted}, {31'd0, exp_abort}, tag);
    irq_k = -1;
    @(negedge clk); @(negedge clk);
  endtask

  logic [31:0] snap [8];

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    run_chk = 1;
    @(negedge clk);
    // R1: reset state
    chk(busy, 0, "R1 busy");
    chk(mem_req, 0, "R1 mem_req");
    chk(done, 0, "R1 done");
    chk(aborted, 0, "R1 aborted");
    chk(restart_pc, 0, "R1 restart_pc");
    for (int i = 0; i < 8; i++) snap[i] = 0;
    chk_regs(snap, "R1 regs zero");

    for (int i = 0; i < 6; i++) rf_write(i, 32'hC0DE_0000 | (i * 32'h111));
    rf_write(6, 32'h0000_2000);
    rf_write(7, 32'h0000_4000);
    chk_regs(m_rf, "R11 idle writes");

    // R2 R9: upward store with writeback
    op(8'b0010_1101, 6, 0, 0, 1, -1, 0, 32'h100, 0, 0, "R2 store up done");
    chk_regs(m_rf, "R9 store up wb");
    // R4: push form including the base register, with wait states
    op(8'b1100_0110, 7, 1, 0, 1, -1, 1, 32'h104, 0, 0, "R4 push done");
    chk_regs(m_rf, "R9 push wb");
    // R2: pop form reads the pushed words back
    op(8'b0000_0110, 7, 0, 1, 1, -1, 0, 32'h108, 0, 0, "R2 pop done");
    chk_regs(m_rf, "R5 pop regs");

    // R5 R7 R9: load abandoned after two beats, then replayed
    snap = m_rf;
    op(8'b0011_1000, 6, 0, 1, 1, 1, 0, 32'h10C, 1, 0, "R7 mid abort");
    chk_regs(snap, "R5 regs after abort");
    chk(restart_pc, 32'h10C, "R8 restart_pc after abort");
    op(8'b0011_1000, 6, 0, 1, 1, -1, 0, 32'h10C, 0, 0, "R7 replay done");
    chk_regs(m_rf, "R9 replay regs");

    // R7: interrupt already pending at start
    snap = m_rf;
    op(8'b0000_0011, 6, 0, 0, 1, 0, 0, 32'h110, 1, 0, "R7 abort at start");
    chk_regs(snap, "R9 no wb on abort");
    chk(restart_pc, 32'h110, "R8 restart_pc start abort");

    // R3: interrupt during a waiting beat; that beat still completes
    snap = m_rf;
    op(8'b0000_0111, 6, 0, 0, 1, 1, 3, 32'h114, 1, 0, "R3 inflight abort");
    chk_regs(snap, "R5 regs after inflight abort");
    op(8'b0000_0111, 6, 0, 0, 1, -1, 3, 32'h114, 0, 0, "R3 inflight replay");

    // R7: interrupt arriving with the last acknowledge does not abort
    op(8'b0000_1100, 6, 0, 1, 1, 1, 0, 32'h118, 0, 0, "R7 last beat completes");
    chk_regs(m_rf, "R6 regs at done");
    chk(restart_pc, 32'h110 + 32'h4, "R8 restart_pc held");

    // R9: base register in load list keeps loaded word
    op(8'b0100_0001, 6, 0, 1, 1, -1, 0, 32'h11C, 0, 0, "R9 base in list");
    chk_regs(m_rf, "R9 loaded base wins");

    // R10: empty list
    snap = m_rf;
    op(8'b0000_0000, 6, 0, 0, 1, -1, 0, 32'h120, 0, 0, "R10 empty done");
    chk_regs(snap, "R10 base unchanged");

    // R11: start and register write while busy are ignored
    rf_write(6, 32'h0000_3000);
    op(8'b0000_1111, 6, 0, 0, 1, -1, 2, 32'h124, 0, 1, "R11 busy intrude");
    chk_regs(m_rf, "R11 regs untouched");

    // R2: decrement-before load without writeback
    op(8'b0000_0011, 7, 1, 1, 0, -1, 0, 32'h128, 0, 0, "R2 load desc");
    chk_regs(m_rf, "R2 load desc regs");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule